// File: doc/BRIEF.md
# 12-bit Word to Byte Packer

This block moves data between a memory that holds 12-bit words and a sector store that holds 8-bit bytes, in either direction. In byte mode every word carries a single byte in its low eight bits. In packed mode each pair of words occupies three bytes. The first word of a pair fills the first byte and the low nibble of the middle byte. The second word fills the high nibble of the middle byte and the whole third byte. A packed transfer never spans more than one 256-byte sector, so it moves at most 170 words and the last byte of the sector is left unused.

A transfer starts with a one-cycle `start` pulse. The inputs sampled on that pulse are a direction, a mode bit, a word count held as a 12-bit two's-complement negative value, a 15-bit memory address and a starting sector number. The sector number limits how many bytes a byte-mode transfer may take before it reaches the end of the track. Words move on one valid/ready channel and bytes on another, at most one item per cycle on each. Every word handed over comes with its memory address, and that address steps only within its 4K bank. When the last byte has been handled, `done` pulses. The block then reports the advanced count and address, together with a flag that is set if the count did not reach zero.

Top module: `word_byte_packer`

## Requirements
- R1: The number of words requested is 4096 minus `neg_count`, so a value of 0 requests 4096 words. An uncapped transfer moves exactly that many words.
- R2: In byte mode (`mode8`=1), word i maps to byte i. A write emits bits 7:0 of the word. A read returns the byte with bits 11:8 set to zero.
- R3: In packed mode, word 2k maps into byte 3k (bits 7:0 of the word) and into bits 3:0 of byte 3k+1 (bits 11:8 of the word).
- R4: In packed mode, word 2k+1 maps into bits 7:4 of byte 3k+1 (bits 3:0 of the word) and into byte 3k+2 (bits 11:4 of the word). On a write whose count ends on an even-position word, byte 3k+1 is still emitted, with bits 7:4 set to zero.
- R5: In packed mode, the data byte count is (3·words+1)/2. If that count exceeds 256, it is cut to 256 and the word count is cut to 170.
- R6: In byte mode, the word count is limited to (40 − sector)·256. A sector number of 40 or more gives zero words, and `done` then follows `start` by one cycle with no data moved.
- R7: A write (`write_dir`=1) emits zero bytes after the last data byte until the total byte count is a multiple of 256.
- R8: A read (`write_dir`=0) takes exactly the data byte count from the byte channel, and discards any byte left over after the last word. A byte presented with `in_byte_absent`=1 is used as zero.
- R9: `word_addr` gives the address of each word as it is transferred. The first word uses `mem_addr`. Each later word adds one modulo 4096 in bits 11:0, and bits 14:12 never change during the transfer.
- R10: At `done`, `final_count` = (`neg_count` + words moved) mod 4096 and `final_addr` = {bank, (offset + words moved) mod 4096}. `incomplete` is 1 exactly when `final_count` is nonzero.
- R11: A byte is transferred on a cycle with `out_byte_valid`&`out_byte_ready` (or `in_byte_valid`&`in_byte_ready`), and a word on the matching word handshake. While a presented output is not accepted and its source holds, the output stays valid and unchanged.
- R12: After reset, `busy`, `done`, the results and all handshake outputs are zero. `start` is ignored while `busy`=1. `done` is a one-cycle pulse in the cycle after the final handshake, and `busy` is low while `done` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a transfer (ignored while busy) |
| write_dir | input | 1 | 1: words to bytes, 0: bytes to words |
| mode8 | input | 1 | 1: byte mode, 0: packed mode |
| neg_count | input | 12 | Negative word count |
| mem_addr | input | 15 | Start address, bank in bits 14:12 |
| sector | input | 6 | Starting sector number on the track |
| wr_word_valid | input | 1 | Write word offered |
| wr_word_data | input | 12 | Write word |
| wr_word_ready | output | 1 | Write word accepted |
| rd_word_valid | output | 1 | Read word offered |
| rd_word_data | output | 12 | Read word |
| rd_word_ready | input | 1 | Read word accepted |
| word_addr | output | 15 | Address of the current word |
| out_byte_valid | output | 1 | Byte offered to the sector store |
| out_byte_data | output | 8 | Byte to the sector store |
| out_byte_ready | input | 1 | Sector store accepts the byte |
| in_byte_valid | input | 1 | Byte offered from the sector store |
| in_byte_data | input | 8 | Byte from the sector store |
| in_byte_absent | input | 1 | Byte missing on the media, read as zero |
| in_byte_ready | output | 1 | Byte from the sector store accepted |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| final_count | output | 12 | Advanced word count |
| final_addr | output | 15 | Advanced address |
| incomplete | output | 1 | Final count is nonzero |

## Verification
Packed writes of four words and of three words separate a count that ends on a full triple from one that ends on a lone middle byte. Requests of 200 and 4096 words push packed transfers past the 170-word cap. Byte-mode runs that start at sectors 38, 39, 0 and 40 separate an uncapped count, a track-limited count, a 4096-word run that wraps the offset back to its start, and an empty transfer. Reads that mark their tail bytes as absent show that zero substitution is separate from packing. Random throttling on both channels, together with a stray `start` during a transfer, shows that handshake stalls and restarts do not change the data or the results.

// File: rtl/wbp_pkg.sv
package wbp_pkg;
    localparam int WORD_W        = 12;
    localparam int BYTE_W        = 8;
    localparam int BANK_W        = 3;
    localparam int SECT_W        = 6;
    localparam int SECTOR_BYTES  = 256;
    localparam int TRACK_SECTORS = 40;
    localparam int NIB_W   = WORD_W - BYTE_W;
    localparam int ADDR_W  = BANK_W + WORD_W;
    localparam int WCNT_W  = WORD_W + 1;
    localparam int BCNT_W  = $clog2(TRACK_SECTORS * SECTOR_BYTES + 1);
    localparam int SB_W    = $clog2(SECTOR_BYTES);
    localparam int PACK_CAP = (SECTOR_BYTES * 2) / 3;

    typedef logic [WCNT_W-1:0] wcnt_t;
    typedef logic [BCNT_W-1:0] bcnt_t;

    typedef struct packed {
        wcnt_t words;
        bcnt_t bytes;
    } plan_t;

    typedef enum logic [1:0] {PH_LO, PH_MID, PH_HI} phase_t;

    // Word and byte totals for one transfer, after the mode-specific caps.
    function automatic plan_t make_plan(input logic [WORD_W-1:0] neg_wc,
                                        input logic m8,
                                        input logic [SECT_W-1:0] sect);
        plan_t p;
        int want;
        int room;
        int trip;
        want = (1 << WORD_W) - int'(neg_wc);
        if (m8) begin
            room = (int'(sect) < TRACK_SECTORS) ?
                   (TRACK_SECTORS - int'(sect)) * SECTOR_BYTES : 0;
            if (want > room) want = room;
            p.words = WCNT_W'(want);
            p.bytes = BCNT_W'(want);
        end else begin
            trip = (want * 3 + 1) / 2;
            if (trip > SECTOR_BYTES) begin
                trip = SECTOR_BYTES;
                want = PACK_CAP;
            end
            p.words = WCNT_W'(want);
            p.bytes = BCNT_W'(trip);
        end
        return p;
    endfunction
endpackage

// File: rtl/wbp_pack.sv
module wbp_pack
    import wbp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              go,
    input  logic              mode8,
    input  wcnt_t             words,
    input  logic              wd_valid,
    input  logic [WORD_W-1:0] wd_data,
    output logic              wd_ready,
    output logic              by_valid,
    output logic [BYTE_W-1:0] by_data,
    input  logic              by_ready,
    output logic              word_fire,
    output logic              last
);
    logic              act;
    wcnt_t             wl, nwl;
    phase_t            ph, nph;
    logic [NIB_W-1:0]  nib;
    logic [BYTE_W-1:0] hi;
    bcnt_t             bcnt, bump;
    logic              by_fire;

    always_comb begin
        by_valid = 1'b0;
        by_data  = '0;
        wd_ready = 1'b0;
        nwl      = wl;
        nph      = ph;
        if (act) begin
            if (mode8 || ph == PH_LO) begin
                if (wl != '0) begin
                    by_valid = wd_valid;
                    by_data  = wd_data[BYTE_W-1:0];
                    wd_ready = by_ready;
                    nwl      = wl - 1'b1;
                    nph      = mode8 ? PH_LO : PH_MID;
                end else begin
                    by_valid = (bcnt[SB_W-1:0] != '0);
                end
            end else if (ph == PH_MID) begin
                if (wl != '0) begin
                    by_valid = wd_valid;
                    by_data  = {wd_data[NIB_W-1:0], nib};
                    wd_ready = by_ready;
                    nwl      = wl - 1'b1;
                    nph      = PH_HI;
                end else begin
                    by_valid = 1'b1;
                    by_data  = {{(BYTE_W-NIB_W){1'b0}}, nib};
                    nph      = PH_LO;
                end
            end else begin
                by_valid = 1'b1;
                by_data  = hi;
                nph      = PH_LO;
            end
        end
    end

    assign by_fire   = by_valid & by_ready;
    assign word_fire = wd_valid & wd_ready;
    assign bump      = bcnt + 1'b1;
    assign last      = by_fire && nwl == '0 && nph == PH_LO && bump[SB_W-1:0] == '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            act  <= 1'b0;
            wl   <= '0;
            ph   <= PH_LO;
            nib  <= '0;
            hi   <= '0;
            bcnt <= '0;
        end else if (go) begin
            act  <= 1'b1;
            wl   <= words;
            ph   <= PH_LO;
            bcnt <= '0;
        end else if (act && by_fire) begin
            wl   <= nwl;
            ph   <= nph;
            bcnt <= bump;
            if (ph == PH_LO) nib <= wd_data[WORD_W-1:BYTE_W];
            if (ph == PH_MID && wl != '0) hi <= wd_data[WORD_W-1:NIB_W];
            if (last) act <= 1'b0;
        end
    end
endmodule

// File: rtl/wbp_unpack.sv
module wbp_unpack
    import wbp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              go,
    input  logic              mode8,
    input  wcnt_t             words,
    input  bcnt_t             bytes,
    input  logic              by_valid,
    input  logic [BYTE_W-1:0] by_data,
    input  logic              by_absent,
    output logic              by_ready,
    output logic              wd_valid,
    output logic [WORD_W-1:0] wd_data,
    input  logic              wd_ready,
    output logic              word_fire,
    output logic              last
);
    logic              act;
    wcnt_t             wl, nwl;
    bcnt_t             bl;
    phase_t            ph, nph;
    logic [BYTE_W-1:0] lo;
    logic [NIB_W-1:0]  nib;
    logic [BYTE_W-1:0] b;
    logic              by_fire;

    assign b = by_absent ? '0 : by_data;

    always_comb begin
        by_ready = 1'b0;
        wd_valid = 1'b0;
        wd_data  = '0;
        nwl      = wl;
        nph      = ph;
        if (act) begin
            if (wl == '0) begin
                by_ready = 1'b1;
            end else if (mode8) begin
                wd_valid = by_valid;
                wd_data  = {{NIB_W{1'b0}}, b};
                by_ready = wd_ready;
                nwl      = wl - 1'b1;
            end else begin
                case (ph)
                    PH_LO: begin
                        by_ready = 1'b1;
                        nph      = PH_MID;
                    end
                    PH_MID: begin
                        wd_valid = by_valid;
                        wd_data  = {b[NIB_W-1:0], lo};
                        by_ready = wd_ready;
                        nwl      = wl - 1'b1;
                        nph      = PH_HI;
                    end
                    default: begin
                        wd_valid = by_valid;
                        wd_data  = {b, nib};
                        by_ready = wd_ready;
                        nwl      = wl - 1'b1;
                        nph      = PH_LO;
                    end
                endcase
            end
        end
    end

    assign by_fire   = by_valid & by_ready;
    assign word_fire = wd_valid & wd_ready;
    assign last      = by_fire && bl == bcnt_t'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            act <= 1'b0;
            wl  <= '0;
            bl  <= '0;
            ph  <= PH_LO;
            lo  <= '0;
            nib <= '0;
        end else if (go) begin
            act <= 1'b1;
            wl  <= words;
            bl  <= bytes;
            ph  <= PH_LO;
        end else if (act && by_fire) begin
            wl <= nwl;
            ph <= nph;
            bl <= bl - 1'b1;
            if (ph == PH_LO)  lo  <= b;
            if (ph == PH_MID) nib <= b[BYTE_W-1:NIB_W];
            if (last) act <= 1'b0;
        end
    end
endmodule

// File: rtl/word_byte_packer.sv
module word_byte_packer
    import wbp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              write_dir,
    input  logic              mode8,
    input  logic [WORD_W-1:0] neg_count,
    input  logic [ADDR_W-1:0] mem_addr,
    input  logic [SECT_W-1:0] sector,
    input  logic              wr_word_valid,
    input  logic [WORD_W-1:0] wr_word_data,
    output logic              wr_word_ready,
    output logic              rd_word_valid,
    output logic [WORD_W-1:0] rd_word_data,
    input  logic              rd_word_ready,
    output logic [ADDR_W-1:0] word_addr,
    output logic              out_byte_valid,
    output logic [BYTE_W-1:0] out_byte_data,
    input  logic              out_byte_ready,
    input  logic              in_byte_valid,
    input  logic [BYTE_W-1:0] in_byte_data,
    input  logic              in_byte_absent,
    output logic              in_byte_ready,
    output logic              busy,
    output logic              done,
    output logic [WORD_W-1:0] final_count,
    output logic [ADDR_W-1:0] final_addr,
    output logic              incomplete
);
    plan_t             plan;
    logic              launch, go_w, go_r, mode_q;
    logic              wfire_w, wfire_r, last_w, last_r;
    logic [BANK_W-1:0] bank;
    logic [WORD_W-1:0] off, pend_cnt, pend_off;
    logic [WORD_W-1:0] move;

    assign plan   = make_plan(neg_count, mode8, sector);
    assign move   = plan.words[WORD_W-1:0];
    assign launch = start & ~busy;
    assign go_w   = launch &  write_dir & (plan.words != '0);
    assign go_r   = launch & ~write_dir & (plan.words != '0);

    wbp_pack u_pack (
        .clk(clk), .rst(rst), .go(go_w), .mode8(mode_q), .words(plan.words),
        .wd_valid(wr_word_valid), .wd_data(wr_word_data), .wd_ready(wr_word_ready),
        .by_valid(out_byte_valid), .by_data(out_byte_data), .by_ready(out_byte_ready),
        .word_fire(wfire_w), .last(last_w)
    );

    wbp_unpack u_unpack (
        .clk(clk), .rst(rst), .go(go_r), .mode8(mode_q), .words(plan.words),
        .bytes(plan.bytes),
        .by_valid(in_byte_valid), .by_data(in_byte_data), .by_absent(in_byte_absent),
        .by_ready(in_byte_ready),
        .wd_valid(rd_word_valid), .wd_data(rd_word_data), .wd_ready(rd_word_ready),
        .word_fire(wfire_r), .last(last_r)
    );

    assign word_addr = {bank, off};

    always_ff @(posedge clk) begin
        if (rst) begin
            busy        <= 1'b0;
            done        <= 1'b0;
            mode_q      <= 1'b0;
            bank        <= '0;
            off         <= '0;
            pend_cnt    <= '0;
            pend_off    <= '0;
            final_count <= '0;
            final_addr  <= '0;
            incomplete  <= 1'b0;
        end else begin
            done <= 1'b0;
            if (launch) begin
                bank     <= mem_addr[ADDR_W-1:WORD_W];
                off      <= mem_addr[WORD_W-1:0];
                mode_q   <= mode8;
                pend_cnt <= neg_count + move;
                pend_off <= mem_addr[WORD_W-1:0] + move;
                if (plan.words == '0) begin
                    done        <= 1'b1;
                    final_count <= neg_count;
                    final_addr  <= mem_addr;
                    incomplete  <= (neg_count != '0);
                end else begin
                    busy <= 1'b1;
                end
            end else begin
                if (wfire_w | wfire_r) off <= off + 1'b1;
                if (busy && (last_w | last_r)) begin
                    busy        <= 1'b0;
                    done        <= 1'b1;
                    final_count <= pend_cnt;
                    final_addr  <= {bank, pend_off};
                    incomplete  <= (pend_cnt != '0);
                end
            end
        end
    end
endmodule

module word_byte_packer_chk
    import wbp_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              busy,
    input logic              done,
    input logic              incomplete,
    input logic [WORD_W-1:0] final_count,
    input logic [ADDR_W-1:0] word_addr,
    input logic              wr_word_valid,
    input logic              wr_word_ready,
    input logic              rd_word_valid,
    input logic              rd_word_ready,
    input logic              out_byte_valid,
    input logic              in_byte_ready
);
    assert_idle_quiet_R12: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !(out_byte_valid || rd_word_valid || wr_word_ready || in_byte_ready));

    assert_done_not_busy_R12: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    assert_incomplete_flag_R10: assert property (@(posedge clk) disable iff (rst)
        done |-> (incomplete == (final_count != '0)));

    assert_bank_fixed_R9: assert property (@(posedge clk) disable iff (rst)
        ($past(busy) && busy) |-> word_addr[ADDR_W-1:WORD_W] == $past(word_addr[ADDR_W-1:WORD_W]));

    assert_addr_step_R9: assert property (@(posedge clk) disable iff (rst)
        ((wr_word_valid && wr_word_ready) || (rd_word_valid && rd_word_ready)) |=>
        word_addr[WORD_W-1:0] == $past(word_addr[WORD_W-1:0]) + WORD_W'(1));
endmodule

bind word_byte_packer word_byte_packer_chk u_chk (
    .clk(clk), .rst(rst), .busy(busy), .done(done), .incomplete(incomplete),
    .final_count(final_count), .word_addr(word_addr),
    .wr_word_valid(wr_word_valid), .wr_word_ready(wr_word_ready),
    .rd_word_valid(rd_word_valid), .rd_word_ready(rd_word_ready),
    .out_byte_valid(out_byte_valid), .in_byte_ready(in_byte_ready)
);

// File: tb/word_byte_packer_test.sv
module word_byte_packer_test;
    logic        clk = 1'b0;
    logic        rst;
    logic        start, write_dir, mode8;
    logic [11:0] neg_count;
    logic [14:0] mem_addr;
    logic [5:0]  sector;
    logic        wr_word_valid;
    logic [11:0] wr_word_data;
    logic        wr_word_ready;
    logic        rd_word_valid;
    logic [11:0] rd_word_data;
    logic        rd_word_ready;
    logic [14:0] word_addr;
    logic        out_byte_valid;
    logic [7:0]  out_byte_data;
    logic        out_byte_ready;
    logic        in_byte_valid;
    logic [7:0]  in_byte_data;
    logic        in_byte_absent;
    logic        in_byte_ready;
    logic        busy, done, incomplete;
    logic [11:0] final_count;
    logic [14:0] final_addr;

    int          n_chk = 0;
    int          n_fail = 0;
    int          gcyc = 0;
    int unsigned seed = 32'h2468_ace1;

    always #2 clk = ~clk;

    word_byte_packer uut (.*);

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic bit coin(input bit thr);
        seed = seed * 32'd1103515245 + 32'd12345;
        return !thr || seed[17];
    endfunction

    always @(posedge clk) begin
        gcyc++;
        if (gcyc > 190000) begin
            n_chk++;
            n_fail++;
            $display("FAIL R12: watchdog expired, actual %0d expected below 190000", gcyc);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    function automatic int exp_words(input bit m8, input int negc, input int sect);
        int w = 4096 - negc;
        if (m8) begin
            int room = (sect < 40) ? (40 - sect) * 256 : 0;
            if (w > room) w = room;
        end else if ((3 * w + 1) / 2 > 256) begin
            w = 170;
        end
        return w;
    endfunction

    function automatic int exp_bytes(input bit m8, input int w);
        if (m8) return w;
        if (w == 170) return 256;
        return (3 * w + 1) / 2;
    endfunction

    function automatic int exp_addr(input int addr, input int idx);
        return (addr & 'h7000) | ((addr + idx) & 'hFFF);
    endfunction

    task automatic final_checks(input int negc, input int addr, input int w,
                                input int dcyc, input int last_hs, input bit got,
                                input string tag);
        int fc = (negc + w) & 'hFFF;
        chk(got, {tag, " R12 done seen"}, got, 1);
        chk(dcyc == last_hs + 1, {tag, " R12 done timing"}, dcyc, last_hs + 1);
        chk(final_count == fc, {tag, " R10 count"}, final_count, fc);
        chk(final_addr == exp_addr(addr, w), {tag, " R10 addr"}, final_addr, exp_addr(addr, w));
        chk(incomplete == (fc != 0), {tag, " R10 incomplete"}, incomplete, fc != 0);
        @(negedge clk);
        #1;
        chk(!done && !busy, {tag, " R12 pulse"}, {done, busy}, 0);
    endtask

    task automatic run_write(input bit m8, input int negc, input int addr, input int sect,
                             input int base, input bit thr, input int poke, input string ctag);
        int w, bc, wbc, ntrue, widx, bidx, last_hs, dcyc, pd;
        bit got, src_v, pv;
        int words[$];
        int xb[$];
        ntrue = 4096 - negc;
        w = exp_words(m8, negc, sect);
        bc = exp_bytes(m8, w);
        wbc = ((bc + 255) / 256) * 256;
        for (int i = 0; i < ntrue; i++) words.push_back((base + i * 1237) & 'hFFF);
        for (int i = 0; i < wbc; i++) xb.push_back(0);
        for (int i = 0; i < w; i++) begin
            if (m8) xb[i] = words[i] & 'hFF;
            else begin
                int p = 3 * (i / 2);
                if (i % 2 == 0) begin
                    xb[p] = words[i] & 'hFF;
                    xb[p + 1] = xb[p + 1] | ((words[i] >> 8) & 'hF);
                end else begin
                    xb[p + 1] = xb[p + 1] | ((words[i] & 'hF) << 4);
                    xb[p + 2] = (words[i] >> 4) & 'hFF;
                end
            end
        end
        widx = 0; bidx = 0; last_hs = 0; dcyc = 0; got = 0; src_v = 0; pv = 0; pd = 0;
        for (int cyc = 0; cyc < 30000 && !got; cyc++) begin
            @(negedge clk);
            start = (cyc == 0) || (cyc == poke);
            if (cyc == 0) begin
                write_dir = 1'b1; mode8 = m8; neg_count = 12'(negc);
                mem_addr = 15'(addr); sector = 6'(sect);
            end else if (cyc == poke) begin
                write_dir = 1'b0; mode8 = !m8; neg_count = 12'h001;
                mem_addr = 15'h0; sector = 6'd5;
            end
            if (!src_v) src_v = (widx < ntrue) && coin(thr);
            wr_word_valid = src_v;
            wr_word_data = (widx < ntrue) ? 12'(words[widx]) : 12'h0;
            out_byte_ready = coin(thr);
            #1;
            if (done) begin
                got = 1; dcyc = cyc;
            end else begin
                if (cyc == 0) chk(!busy && !out_byte_valid && !wr_word_ready, "R12 idle before launch", busy, 0);
                if (pv) chk(out_byte_valid && out_byte_data == 8'(pd), "R11 hold", out_byte_data, pd);
                if (out_byte_valid && out_byte_ready) begin
                    string t;
                    if (bidx >= bc) t = "R7 pad";
                    else if (m8) t = "R2 byte";
                    else if (bidx % 3 == 2) t = "R4 byte";
                    else if (bidx % 3 == 1) t = "R3 R4 byte";
                    else t = "R3 byte";
                    chk(bidx < wbc && out_byte_data == 8'(xb[bidx]), t, out_byte_data,
                        (bidx < wbc) ? xb[bidx] : -1);
                    bidx++;
                    last_hs = cyc;
                end
                if (wr_word_valid && wr_word_ready) begin
                    chk(word_addr == 15'(exp_addr(addr, widx)), "R9 word address", word_addr, exp_addr(addr, widx));
                    widx++;
                    src_v = 0;
                end
                pv = out_byte_valid && !out_byte_ready;
                pd = out_byte_data;
            end
        end
        start = 0; wr_word_valid = 0; out_byte_ready = 0;
        chk(bidx == wbc, m8 ? "R6 R7 byte total" : "R5 R7 byte total", bidx, wbc);
        chk(widx == w, {ctag, " word total"}, widx, w);
        if (poke > 0) chk(final_count == 12'((negc + w) & 'hFFF), "R12 start ignored while busy", final_count, (negc + w) & 'hFFF);
        final_checks(negc, addr, w, dcyc, last_hs, got, ctag);
    endtask

    task automatic run_read(input bit m8, input int negc, input int addr, input int sect,
                            input int base, input bit thr, input int absent_from, input string ctag);
        int w, bc, widx, bidx, last_hs, dcyc;
        bit got, src_v;
        int eff[$];
        int raw[$];
        int xw[$];
        string sfx;
        w = exp_words(m8, negc, sect);
        bc = exp_bytes(m8, w);
        sfx = (absent_from < bc) ? " R8" : "";
        for (int i = 0; i < bc; i++) begin
            raw.push_back((base * 7 + i * 53 + 11) & 'hFF);
            eff.push_back((i >= absent_from) ? 0 : raw[i]);
        end
        for (int i = 0; i < w; i++) begin
            if (m8) xw.push_back(eff[i]);
            else begin
                int p = 3 * (i / 2);
                if (i % 2 == 0) xw.push_back(eff[p] | ((eff[p + 1] & 'hF) << 8));
                else xw.push_back(((eff[p + 1] >> 4) & 'hF) | (eff[p + 2] << 4));
            end
        end
        widx = 0; bidx = 0; last_hs = 0; dcyc = 0; got = 0; src_v = 0;
        for (int cyc = 0; cyc < 30000 && !got; cyc++) begin
            @(negedge clk);
            start = (cyc == 0);
            if (cyc == 0) begin
                write_dir = 1'b0; mode8 = m8; neg_count = 12'(negc);
                mem_addr = 15'(addr); sector = 6'(sect);
            end
            if (!src_v) src_v = (bidx < bc) && coin(thr);
            in_byte_valid = src_v;
            in_byte_data = (bidx < bc) ? ((bidx >= absent_from) ? 8'(raw[bidx] ^ 'hA5) : 8'(raw[bidx])) : 8'h0;
            in_byte_absent = (bidx >= absent_from);
            rd_word_ready = coin(thr);
            #1;
            if (done) begin
                got = 1; dcyc = cyc;
            end else begin
                if (rd_word_valid && rd_word_ready) begin
                    string t;
                    if (m8) t = {"R2 word", sfx};
                    else if (widx % 2 == 0) t = {"R3 word", sfx};
                    else t = {"R4 word", sfx};
                    chk(widx < w && rd_word_data == 12'((widx < w) ? xw[widx] : 0), t, rd_word_data,
                        (widx < w) ? xw[widx] : -1);
                    chk(word_addr == 15'(exp_addr(addr, widx)), "R9 word address", word_addr, exp_addr(addr, widx));
                    widx++;
                end
                if (in_byte_valid && in_byte_ready) begin
                    bidx++;
                    src_v = 0;
                    last_hs = cyc;
                end
            end
        end
        start = 0; in_byte_valid = 0; rd_word_ready = 0; in_byte_absent = 0;
        chk(bidx == bc, "R8 bytes consumed", bidx, bc);
        chk(widx == w, {ctag, " word total"}, widx, w);
        final_checks(negc, addr, w, dcyc, last_hs, got, ctag);
    endtask

    initial begin
        rst = 1; start = 0; write_dir = 0; mode8 = 0; neg_count = 0; mem_addr = 0; sector = 0;
        wr_word_valid = 0; wr_word_data = 0; rd_word_ready = 0; out_byte_ready = 0;
        in_byte_valid = 0; in_byte_data = 0; in_byte_absent = 0;
        repeat (3) @(negedge clk);
        rst = 0;
        #1;
        chk(!busy && !done && !incomplete, "R12 reset flags", {busy, done, incomplete}, 0);
        chk(final_count == 0 && final_addr == 0, "R12 reset results", final_addr, 0);
        chk(!out_byte_valid && !rd_word_valid && !wr_word_ready && !in_byte_ready,
            "R12 reset handshakes", {out_byte_valid, rd_word_valid, wr_word_ready, in_byte_ready}, 0);

        run_write(0, 4092, 'h1234, 0, 'h5A1, 0, -1, "R1");
        run_write(0, 4093, 'h3100, 0, 'h0F3, 1, 5, "R4 R1");
        run_write(0, 4096 - 200, 'h7FF0, 0, 'h777, 1, -1, "R5");
        run_write(1, 4096 - 300, 'h2FFE, 38, 'h123, 1, -1, "R6 R1");
        run_write(1, 4096 - 300, 'h4000, 39, 'hABC, 0, -1, "R6");
        run_read(0, 4091, 'h1FFE, 0, 3, 1, 4, "R1");
        run_read(0, 0, 'h6123, 0, 9, 1, 300, "R5");
        run_read(1, 4076, 'h0500, 0, 21, 1, 15, "R1");
        run_read(1, 4000, 'h0321, 40, 5, 0, 0, "R6");
        run_write(1, 0, 'h5ABC, 0, 'h010, 0, -1, "R1");

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule